// File: doc/BRIEF.md
# Memory Write Request Packer

This block turns one user write request into a memory write transaction-layer packet. It drives the packet onto a 128-bit transmit stream that has valid, ready, start-of-packet and end-of-packet signals. A request carries a 64-bit byte address, a payload length of one to four dwords, first and last byte-enable nibbles, and up to four payload dwords. The requester ID, tag, traffic class and attribute fields come from static configuration inputs.

The packer chooses the header size from the address without outside help. An address below 4 GB gets the short three-dword header. In that case the first payload dword shares the opening beat with the header, and any remaining payload dwords move down to the low lanes of a second beat. Any other address gets the four-dword header, which fills the opening beat, and the whole payload follows in a second beat. A request is accepted only while no packet is in flight. It is captured in one cycle and held until the final beat is taken.

The controller has three states. `ST_IDLE` waits for a request. `ST_FIRST` presents the opening beat. `ST_LAST` presents the payload beat of a two-beat packet. Transitions:
- `ST_IDLE` to `ST_FIRST` when a request is taken.
- `ST_FIRST` to `ST_IDLE` when a single-beat packet is taken.
- `ST_FIRST` to `ST_LAST` when the opening beat of a two-beat packet is taken.
- `ST_LAST` to `ST_IDLE` when the payload beat is taken.

Every state holds while `tx_ready` is low.

Top module: `mwr_tlp_packer`

## Requirements
- R1: When address bits 63:32 are all zero the packet uses the three-dword header, with format/type byte 0x40 in header dword 0 bits 31:24. Otherwise it uses the four-dword header, with byte 0x60.
- R2: Header dword 0 carries the traffic class in bits 22:20, the attribute in bits 13:12 and the payload length in dwords in bits 9:0. All its other bits below 24 are zero.
- R3: Header dword 1 carries the requester ID in bits 31:16, the tag in bits 15:8, the last byte enable in bits 7:4 and the first byte enable in bits 3:0. The last byte enable is forced to zero when the length is one.
- R4: Address bits 1:0 are ignored and sent as zero. The four-dword header puts address bits 63:32 in dword 2 and the low address dword in dword 3. The three-dword header puts the low address dword in dword 2.
- R5: A four-dword packet is two beats. The opening beat holds header dwords 0 to 3, with dword 0 in bits 31:0, and has start-of-packet set. The second beat holds payload dword k in bits 32k+31:32k, has zero in lanes beyond the length, and has end-of-packet set.
- R6: A three-dword packet of length one is a single beat. Bits 95:0 hold the header, bits 127:96 hold the payload dword, and start- and end-of-packet are both set.
- R7: A three-dword packet longer than one dword is two beats. The opening beat holds payload dword 0 in bits 127:96. The second beat holds payload dword k+1 in bits 32k+31:32k, has zero in unused lanes, and has end-of-packet set.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data`, `tx_sop` and `tx_eop` hold their values and the packet does not advance.
- R9: `tx_valid` falls in the cycle after the end-of-packet beat is taken. `tx_sop` and `tx_eop` are never high without `tx_valid`.
- R10: `req_ready` is high only while no packet is in flight. A request is taken on an edge where `req_valid` and `req_ready` are both high. Request inputs that change after that edge have no effect on the packet.
- R11: During and right after reset, `tx_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Packer can take a request |
| req_addr | input | 64 | Byte address of the write |
| req_len | input | 3 | Payload length in dwords, 1 to 4 |
| req_first_be | input | 4 | Byte enables of the first payload dword |
| req_last_be | input | 4 | Byte enables of the last payload dword |
| req_data | input | 128 | Payload; dword k in bits 32k+31:32k |
| cfg_req_id | input | 16 | Requester ID |
| cfg_tag | input | 8 | Tag |
| cfg_tc | input | 3 | Traffic class |
| cfg_attr | input | 2 | Attribute bits |
| tx_valid | output | 1 | Transmit beat valid |
| tx_ready | input | 1 | Sink takes the beat |
| tx_data | output | 128 | Transmit beat |
| tx_sop | output | 1 | First beat of a packet |
| tx_eop | output | 1 | Last beat of a packet |

## Verification
The bench builds the packer with its default parameters: a 128-bit beat, a 64-bit address and a four-dword payload limit. With these values every payload length from one to four can be sent in both header formats. The stimulus includes addresses just below and just above the 4 GB line, the all-ones address and addresses whose two low bits are set. Each beat is held in stalls of up to three cycles, so both the single-beat and the two-beat paths through the state machine are reached with back-pressure on every beat.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

    localparam int unsigned DW_BITS = 32;

    localparam logic [7:0] FT_MWR_3DW = 8'h40;
    localparam logic [7:0] FT_MWR_4DW = 8'h60;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_LAST  = 2'd2
    } pk_state_e;

endpackage

// File: rtl/mwr_req_reg.sv
module mwr_req_reg #(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 128,
    parameter int LEN_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LEN_W-1:0]  in_len,
    input  logic [3:0]        in_fbe,
    input  logic [3:0]        in_lbe,
    input  logic [DATA_W-1:0] in_data,
    output logic [ADDR_W-1:0] q_addr,
    output logic [LEN_W-1:0]  q_len,
    output logic [3:0]        q_fbe,
    output logic [3:0]        q_lbe,
    output logic [DATA_W-1:0] q_data
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_addr <= '0;
            q_len  <= '0;
            q_fbe  <= '0;
            q_lbe  <= '0;
            q_data <= '0;
        end else if (load) begin
            q_addr <= in_addr;
            q_len  <= in_len;
            q_fbe  <= in_fbe;
            q_lbe  <= in_lbe;
            q_data <= in_data;
        end
    end

endmodule

// File: rtl/mwr_hdr_build.sv
module mwr_hdr_build
    import mwr_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 3
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [LEN_W-1:0]      len,
    input  logic [3:0]            fbe,
    input  logic [3:0]            lbe,
    input  logic [15:0]           req_id,
    input  logic [7:0]            tag,
    input  logic [2:0]            tc,
    input  logic [1:0]            attr,
    output logic [3:0][DW_BITS-1:0] hdr,
    output logic                  use_4dw
);

    logic [DW_BITS-1:0] addr_hi_dw;
    logic [DW_BITS-1:0] addr_lo_dw;
    logic               upper_nz;
    logic [3:0]         lbe_eff;
    logic [7:0]         fmt_type;

    // Upper address half only exists when the address is wider than a dword.
    generate
        if (ADDR_W > DW_BITS) begin : g_wide
            assign addr_hi_dw = DW_BITS'(addr[ADDR_W-1:DW_BITS]);
            assign upper_nz   = |addr[ADDR_W-1:DW_BITS];
        end else begin : g_narrow
            assign addr_hi_dw = '0;
            assign upper_nz   = 1'b0;
        end
    endgenerate

    // Dword-aligned: the two low byte-address bits are masked off.
    assign addr_lo_dw = addr[DW_BITS-1:0] & ~DW_BITS'(3);

    always_comb begin
        use_4dw  = upper_nz;
        fmt_type = upper_nz ? FT_MWR_4DW : FT_MWR_3DW;
        lbe_eff  = (len == LEN_W'(1)) ? 4'h0 : lbe;

        hdr[0] = {fmt_type, 1'b0, tc, 6'b0, attr, 2'b0, 10'(len)};
        hdr[1] = {req_id, tag, lbe_eff, fbe};
        if (upper_nz) begin
            hdr[2] = addr_hi_dw;
            hdr[3] = addr_lo_dw;
        end else begin
            hdr[2] = addr_lo_dw;
            hdr[3] = '0;
        end
    end

endmodule

// File: rtl/mwr_beat_mux.sv
module mwr_beat_mux
    import mwr_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int LEN_W  = 3
) (
    input  logic [3:0][DW_BITS-1:0] hdr,
    input  logic                    use_4dw,
    input  logic [LEN_W-1:0]        len,
    input  logic [DATA_W-1:0]       payload,
    input  logic                    sel_second,
    output logic [DATA_W-1:0]       beat,
    output logic                    two_beats
);

    localparam int LANES = DATA_W / DW_BITS;

    logic [DATA_W-1:0] first_beat;
    logic [DATA_W-1:0] pay_direct;
    logic [DATA_W-1:0] pay_shift;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            // Payload in place, lanes past the length cleared (four-dword format).
            assign pay_direct[i*DW_BITS +: DW_BITS] =
                (LEN_W'(i) < len) ? payload[i*DW_BITS +: DW_BITS] : '0;

            // Payload moved down one lane (three-dword format, second beat).
            if (i + 1 < LANES) begin : g_sh
                assign pay_shift[i*DW_BITS +: DW_BITS] =
                    (LEN_W'(i + 1) < len) ? payload[(i+1)*DW_BITS +: DW_BITS] : '0;
            end else begin : g_sh_top
                assign pay_shift[i*DW_BITS +: DW_BITS] = '0;
            end

            // Opening beat: header dwords, with payload dword 0 in lane 3 for the short header.
            if (i < 3) begin : g_hdr
                assign first_beat[i*DW_BITS +: DW_BITS] = hdr[i];
            end else if (i == 3) begin : g_mix
                assign first_beat[i*DW_BITS +: DW_BITS] =
                    use_4dw ? hdr[3] : payload[0 +: DW_BITS];
            end else begin : g_pad
                assign first_beat[i*DW_BITS +: DW_BITS] = '0;
            end
        end
    endgenerate

    assign two_beats = use_4dw || (len > LEN_W'(1));

    always_comb begin
        if (!sel_second) begin
            beat = first_beat;
        end else if (use_4dw) begin
            beat = pay_direct;
        end else begin
            beat = pay_shift;
        end
    end

endmodule

// File: rtl/mwr_tlp_packer.sv
module mwr_tlp_packer
    import mwr_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int ADDR_W = 64,
    parameter int MAX_DW = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [$clog2(MAX_DW+1)-1:0]  req_len,
    input  logic [3:0]                   req_first_be,
    input  logic [3:0]                   req_last_be,
    input  logic [DATA_W-1:0]            req_data,
    input  logic [15:0]                  cfg_req_id,
    input  logic [7:0]                   cfg_tag,
    input  logic [2:0]                   cfg_tc,
    input  logic [1:0]                   cfg_attr,
    output logic                         tx_valid,
    input  logic                         tx_ready,
    output logic [DATA_W-1:0]            tx_data,
    output logic                         tx_sop,
    output logic                         tx_eop
);

    localparam int LEN_W = $clog2(MAX_DW + 1);

    pk_state_e state_q, state_d;

    logic                      load;
    logic [ADDR_W-1:0]         h_addr;
    logic [LEN_W-1:0]          h_len;
    logic [3:0]                h_fbe;
    logic [3:0]                h_lbe;
    logic [DATA_W-1:0]         h_data;
    logic [3:0][DW_BITS-1:0]   hdr;
    logic                      use_4dw;
    logic                      two_beats;
    logic                      sel_second;
    logic [DATA_W-1:0]         beat;

    assign load = req_valid && req_ready;

    mwr_req_reg #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .in_addr (req_addr),
        .in_len  (req_len),
        .in_fbe  (req_first_be),
        .in_lbe  (req_last_be),
        .in_data (req_data),
        .q_addr  (h_addr),
        .q_len   (h_len),
        .q_fbe   (h_fbe),
        .q_lbe   (h_lbe),
        .q_data  (h_data)
    );

    mwr_hdr_build #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_hdr (
        .addr    (h_addr),
        .len     (h_len),
        .fbe     (h_fbe),
        .lbe     (h_lbe),
        .req_id  (cfg_req_id),
        .tag     (cfg_tag),
        .tc      (cfg_tc),
        .attr    (cfg_attr),
        .hdr     (hdr),
        .use_4dw (use_4dw)
    );

    mwr_beat_mux #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_mux (
        .hdr        (hdr),
        .use_4dw    (use_4dw),
        .len        (h_len),
        .payload    (h_data),
        .sel_second (sel_second),
        .beat       (beat),
        .two_beats  (two_beats)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = ST_FIRST;
            end
            ST_FIRST: begin
                if (tx_ready) state_d = two_beats ? ST_LAST : ST_IDLE;
            end
            ST_LAST: begin
                if (tx_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready  = 1'b0;
        tx_valid   = 1'b0;
        tx_sop     = 1'b0;
        tx_eop     = 1'b0;
        sel_second = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_FIRST: begin
                tx_valid = 1'b1;
                tx_sop   = 1'b1;
                tx_eop   = !two_beats;
            end
            ST_LAST: begin
                tx_valid   = 1'b1;
                tx_eop     = 1'b1;
                sel_second = 1'b1;
            end
            default: ;
        endcase
        tx_data = tx_valid ? beat : '0;
    end

endmodule

// File: rtl/mwr_tlp_packer_chk.sv
module mwr_tlp_packer_chk #(
    parameter int DATA_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [DATA_W-1:0] tx_data,
    input logic              tx_sop,
    input logic              tx_eop
);

    AST_FMT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_sop) |-> (tx_data[31:24] == 8'h40 || tx_data[31:24] == 8'h60)); // R1

    AST_LONG_HDR_HIGH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_sop && tx_data[31:24] == 8'h60) |-> (tx_data[95:64] != 32'h0)); // R1

    AST_DW0_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_sop) |-> (tx_data[23] == 1'b0 && tx_data[19:14] == 6'h0 && tx_data[11:10] == 2'h0)); // R2

    AST_LEN_ONE_NO_LAST_BE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_sop && tx_data[9:0] == 10'd1) |-> (tx_data[39:36] == 4'h0)); // R3

    AST_SINGLE_BEAT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_sop && tx_eop) |-> (tx_data[31:24] == 8'h40 && tx_data[9:0] == 10'd1)); // R6

    AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop))); // R8

    AST_VALID_DROPS_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_eop) |=> !tx_valid); // R9

    AST_FRAMING_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sop || tx_eop) |-> tx_valid); // R9

    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !tx_valid); // R10

    AST_TAKE_STARTS_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (tx_valid && tx_sop)); // R10

endmodule

bind mwr_tlp_packer mwr_tlp_packer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_sop    (tx_sop),
    .tx_eop    (tx_eop)
);

// File: tb/mwr_tlp_packer_test.sv
module mwr_tlp_packer_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    localparam logic [15:0] RID  = 16'hBEEF;
    localparam logic [7:0]  TAG  = 8'h5A;
    localparam logic [2:0]  TC   = 3'd5;
    localparam logic [1:0]  ATTR = 2'b10;

    // {address, length, first BE, last BE, stall cycles per beat}
    localparam logic [76:0] VECS [NVEC] = '{
        {64'h0000_0000_1234_5678, 3'd1, 4'hF, 4'hF, 2'd0},
        {64'h0000_0000_8000_0010, 3'd2, 4'hF, 4'h3, 2'd1},
        {64'h0000_0000_0000_0104, 3'd3, 4'h3, 4'hC, 2'd0},
        {64'h0000_0000_FFFF_FFFF, 3'd4, 4'hF, 4'hF, 2'd2},
        {64'h0000_0001_0000_0000, 3'd1, 4'hF, 4'hF, 2'd0},
        {64'hFFFF_FFFF_FFFF_FFFC, 3'd4, 4'hF, 4'hF, 2'd3},
        {64'h8000_0000_0000_0003, 3'd2, 4'h1, 4'h8, 2'd1},
        {64'h0000_0000_0000_0000, 3'd4, 4'hF, 4'hF, 2'd1}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [63:0]  req_addr = '0;
    logic [2:0]   req_len = '0;
    logic [3:0]   req_first_be = '0;
    logic [3:0]   req_last_be = '0;
    logic [127:0] req_data = '0;
    logic         tx_valid;
    logic         tx_ready = 1'b1;
    logic [127:0] tx_data;
    logic         tx_sop;
    logic         tx_eop;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mwr_tlp_packer uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_addr     (req_addr),
        .req_len      (req_len),
        .req_first_be (req_first_be),
        .req_last_be  (req_last_be),
        .req_data     (req_data),
        .cfg_req_id   (RID),
        .cfg_tag      (TAG),
        .cfg_tc       (TC),
        .cfg_attr     (ATTR),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .tx_data      (tx_data),
        .tx_sop       (tx_sop),
        .tx_eop       (tx_eop)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected packet built from the requirements.
    task automatic exp_pkt(input logic [63:0] a, input int len, input logic [3:0] fb,
                           input logic [3:0] lb, input logic [127:0] d,
                           output logic [127:0] b0, output logic [127:0] b1, output int nb);
        logic [31:0]  h0, h1, alo, ahi;
        logic [127:0] dm, ds;
        logic         big;
        big = (a[63:32] != 32'h0);
        h0  = {big ? 8'h60 : 8'h40, 1'b0, TC, 6'b0, ATTR, 2'b0, 10'(len)};
        h1  = {RID, TAG, (len == 1) ? 4'h0 : lb, fb};
        alo = {a[31:2], 2'b00};
        ahi = a[63:32];
        dm  = '0;
        ds  = '0;
        for (int j = 0; j < len; j++) dm[32*j +: 32] = d[32*j +: 32];
        for (int j = 0; j < len - 1; j++) ds[32*j +: 32] = d[32*(j+1) +: 32];
        if (big) begin
            b0 = {alo, ahi, h1, h0};
            b1 = dm;
            nb = 2;
        end else begin
            b0 = {d[31:0], alo, h1, h0};
            b1 = ds;
            nb = (len == 1) ? 1 : 2;
        end
    endtask

    task automatic run_pkt(input logic [63:0] a, input int len, input logic [3:0] fb,
                           input logic [3:0] lb, input logic [127:0] d, input int stall);
        logic [127:0] b0, b1, eb;
        int           nb;
        string        tag;
        exp_pkt(a, len, fb, lb, d, b0, b1, nb);
        tag = (a[63:32] != 0) ? "R5" : ((len == 1) ? "R6" : "R7");

        @(negedge clk);
        chk("R10 idle ready", 128'(req_ready), 128'(1));
        req_valid    = 1'b1;
        req_addr     = a;
        req_len      = 3'(len);
        req_first_be = fb;
        req_last_be  = lb;
        req_data     = d;
        @(posedge clk);
        @(negedge clk);
        // Scramble request inputs after the take edge (R10).
        req_valid    = 1'b0;
        req_addr     = ~a;
        req_len      = 3'(5 - len);
        req_first_be = ~fb;
        req_last_be  = ~lb;
        req_data     = ~d;
        chk("R10 busy not ready", 128'(req_ready), 128'(0));

        // Header field checks on the opening beat.
        chk("R1 format byte", 128'(tx_data[31:24]), 128'(b0[31:24]));
        chk("R2 dword0", 128'(tx_data[31:0]), 128'(b0[31:0]));
        chk("R3 dword1", 128'(tx_data[63:32]), 128'(b1 == b1 ? b0[63:32] : 32'h0));
        chk("R4 address dwords", 128'(tx_data[127:64] & ((a[63:32] != 0) ? {64{1'b1}} : {32'h0, 32'hFFFF_FFFF})),
            128'(b0[127:64] & ((a[63:32] != 0) ? {64{1'b1}} : {32'h0, 32'hFFFF_FFFF})));

        for (int b = 0; b < nb; b++) begin
            eb = (b == 0) ? b0 : b1;
            chk({tag, " beat data"}, tx_data, eb);
            chk({tag, " framing"}, 128'({tx_valid, tx_sop, tx_eop}),
                128'({1'b1, (b == 0), (b == nb - 1)}));
            for (int s = 0; s < stall; s++) begin
                tx_ready = 1'b0;
                @(negedge clk);
                chk("R8 stalled beat held", tx_data, eb);
                chk("R8 stalled framing held", 128'({tx_valid, tx_sop, tx_eop}),
                    128'({1'b1, (b == 0), (b == nb - 1)}));
            end
            tx_ready = 1'b1;
            @(negedge clk);
        end
        chk("R9 valid low after eop", 128'({tx_valid, tx_sop, tx_eop}), 128'(0));
        chk("R10 ready after packet", 128'(req_ready), 128'(1));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // Reset state (R11), with a request offered during reset.
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 valid low in reset", 128'(tx_valid), 128'(0));
        chk("R11 ready high in reset", 128'(req_ready), 128'(1));
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 valid low after reset", 128'(tx_valid), 128'(0));
        chk("R11 ready high after reset", 128'(req_ready), 128'(1));

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [127:0] d;
            for (int j = 0; j < 4; j++) d[32*j +: 32] = 32'hD000_0000 + 32'(i << 8) + 32'(j);
            run_pkt(VECS[i][76:13], int'(VECS[i][12:10]), VECS[i][9:6], VECS[i][5:2],
                    d, int'(VECS[i][1:0]));
        end

        // Idle with no request stays idle (R10).
        @(negedge clk);
        chk("R10 no request no packet", 128'(tx_valid), 128'(0));

        // Boundary: addresses on each side of 4 GB, back to back (R1, R4).
        run_pkt(64'h0000_0000_FFFF_FFFC, 3, 4'hF, 4'hF, 128'h4444_4444_3333_3333_2222_2222_1111_1111, 0);
        run_pkt(64'h0000_0001_0000_0004, 3, 4'hF, 4'hF, 128'h8888_8888_7777_7777_6666_6666_5555_5555, 0);
        // Single-beat packet held under stall (R6, R8).
        run_pkt(64'h0000_0000_0000_0040, 1, 4'h6, 4'h9, 128'hAAAA_AAAA_BBBB_BBBB_CCCC_CCCC_DDDD_DDDD, 3);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule